// File: doc/BRIEF.md
# Dual-Port EDID Responder

This block holds display identification data in one shared 512-byte RAM and returns it to two independent two-wire slave ports: a digital-display port (port 0) and an analog-display port (port 1). A host-side write port loads the RAM one byte per cycle. The sink controller sets `split_mode` to choose the layout. With `split_mode` low, the whole RAM is a single image served only on the digital port. With `split_mode` high, the lower 256 bytes go to the digital port and the upper 256 bytes go to the analog port.

Each slave port oversamples its clock and data lines on the system clock. It detects START and STOP conditions and runs an enumerated state machine. The states are S_IDLE (bus free), S_ADDR (receive the device address), S_ADDR_ACK (acknowledge it), S_WORD and S_WORD_ACK (receive the word offset), S_SEG and S_SEG_ACK (receive the segment number), S_TX and S_TX_ACK (shift a data byte out and sample the master's acknowledge), and S_IGNORE (wait for the next START or STOP).

The transitions are:
- START from any state goes to S_ADDR. STOP from any state goes to S_IDLE.
- The eighth clock of S_ADDR leads to S_ADDR_ACK on an address match and to S_IGNORE otherwise.
- S_ADDR_ACK leads to S_TX for a read, S_SEG for a segment write, and S_WORD for a data write.
- S_WORD and S_SEG each lead to their ACK state after eight bits. Both ACK states then lead to S_IGNORE.
- S_TX leads to S_TX_ACK after eight bits. S_TX_ACK returns to S_TX on an acknowledge and goes to S_IGNORE on a not-acknowledge.

Only the digital port has a segment pointer, which lets it reach bytes beyond the first 256. Both ports read the RAM through a small arbiter that gives port 0 priority.

Top module: `edid_dual_responder`

## Requirements
- R1: After `rst_n` is released, neither port drives its data line. The word offset and the segment pointer both start at 0, so a current-address read on port 0 returns RAM byte 0.
- R2: When `wr_en` is high on a clock edge, the RAM byte at `wr_addr` takes the value `wr_data`, and later reads return it.
- R3: Port 0 acknowledges the 7-bit address 0x50 (write byte 0xA0, read byte 0xA1). With `split_mode` low, writing a word offset and then reading after a repeated START returns the RAM byte at segment*256 + offset. Only bit 0 of the segment is used.
- R4: Each byte read advances the word offset by one. The offset wraps from 0xFF to 0x00 inside the same 256-byte window, so the segment does not change.
- R5: Port 0 acknowledges a write to the 7-bit address 0x30 (byte 0x60), and the following data byte sets the segment pointer. A STOP condition clears the segment pointer to 0.
- R6: With `split_mode` high, port 0 reads only the lower half (address = offset), whatever its segment pointer holds, and port 1 reads only the upper half (address = 256 + offset).
- R7: Port 1 never acknowledges address 0x30. It acknowledges address 0x50 only while `split_mode` is high, and with `split_mode` low it never drives its data line.
- R8: An address other than 0x50, or 0x30 written, is not acknowledged, and the port leaves its data line released for the rest of the transfer.
- R9: After the master answers a data byte with not-acknowledge, the port releases its data line and drives nothing until the next START.
- R10: When both ports request the RAM in the same cycle, port 0 is served first and port 1 one cycle later. Both ports return correct data.
- R11: A one-cycle `sw_reset` pulse clears both ports' word offsets, segment pointer and state machines, and leaves the RAM contents unchanged.
- R12: The word offset is kept across transfers. A read that sends no offset starts at the byte after the last one sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples both slave ports |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| sw_reset | input | 1 | Synchronous controller reset from a software control bit |
| split_mode | input | 1 | 0: one 512-byte image on port 0; 1: two 256-byte images |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | ADDR_W (9) | Host write byte address |
| wr_data | input | 8 | Host write byte |
| hdmi_scl | input | 1 | Port 0 serial clock line |
| hdmi_sda | input | 1 | Port 0 serial data line, as seen on the wire |
| hdmi_sda_oe | output | 1 | Port 0 pull-low enable for the open-drain data pad |
| vga_scl | input | 1 | Port 1 serial clock line |
| vga_sda | input | 1 | Port 1 serial data line, as seen on the wire |
| vga_sda_oe | output | 1 | Port 1 pull-low enable for the open-drain data pad |

## Verification
The bench loads the RAM with a pattern whose lower and upper halves differ, so every read result shows which half and which byte served it. Reads are tried in several forms:
- Offset-then-read transfers show whether the word offset is decoded correctly.
- Transfers that set the segment show whether the segment bit is applied or ignored in each layout.
- Multi-byte bursts starting at 0xFE and 0xFF separate a wrap inside the window from a carry into the segment.
- Current-address reads after a STOP, after a soft reset and after a burst separate a kept offset from a cleared one.
- Simultaneous reads on both ports, started in the same cycle, show whether arbitration corrupts either port's data.
- Addresses that must not be acknowledged, checked on the acknowledge bit and on the pull-low enable, separate the two ports' address decoding across the two layouts.

// File: rtl/edid_pkg.sv
package edid_pkg;

    typedef logic [7:0] edid_byte_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_WORD,
        S_WORD_ACK,
        S_SEG,
        S_SEG_ACK,
        S_TX,
        S_TX_ACK,
        S_IGNORE
    } ddc_state_e;

    localparam logic [6:0] EDID_DEV_ADDR   = 7'h50;
    localparam logic [6:0] SEGPTR_DEV_ADDR = 7'h30;

endpackage

// File: rtl/edid_sync.sv
module edid_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/edid_ram_arb.sv
module edid_ram_arb
    import edid_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  edid_byte_t        wr_data,
    input  logic [1:0]        req,
    input  logic [ADDR_W-1:0] addr0,
    input  logic [ADDR_W-1:0] addr1,
    output logic [1:0]        gnt,
    output edid_byte_t        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    edid_byte_t        mem [DEPTH];
    logic [ADDR_W-1:0] sel_addr;

    // Port 0 always wins a same-cycle conflict; port 1 waits one cycle.
    always_comb begin
        gnt[0]   = req[0];
        gnt[1]   = req[1] & ~req[0];
        sel_addr = req[0] ? addr0 : addr1;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
        if (|req) begin
            rdata <= mem[sel_addr];
        end
    end

    // R10: a stalled port-1 request is granted in the very next cycle
    p_vga_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req[1] && !gnt[1]) |=> gnt[1]);
endmodule

// File: rtl/edid_ddc_port.sv
module edid_ddc_port
    import edid_pkg::*;
#(
    parameter int ADDR_W      = 9,
    parameter int HAS_SEG     = 1,
    parameter int BASE        = 0,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              split,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_gnt,
    input  edid_byte_t        rd_data
);
    logic scl_s, sda_s, scl_q, sda_q;
    logic scl_rise, scl_fall, start_det, stop_det;

    edid_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));
    edid_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

    ddc_state_e state_q, state_d;
    edid_byte_t sh_q, off_q, seg_q, txb_q;
    logic [3:0] cnt_q;
    logic       rw_q, acked_q, oe_q, req_q, pend_q;
    logic       data_en, hit_data, hit_seg, addr_hit, byte_done;

    assign data_en   = (HAS_SEG != 0) || split;
    assign hit_data  = data_en && (sh_q[7:1] == EDID_DEV_ADDR);
    assign hit_seg   = (HAS_SEG != 0) && (sh_q[7:1] == SEGPTR_DEV_ADDR) && !sh_q[0];
    assign addr_hit  = hit_data || hit_seg;
    assign byte_done = scl_fall && (cnt_q == 4'd8);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else if (clr) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = S_ADDR;
        end else if (stop_det) begin
            state_d = S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE:     state_d = S_IDLE;
                S_ADDR:     if (byte_done) state_d = addr_hit ? S_ADDR_ACK : S_IGNORE;
                S_ADDR_ACK: if (scl_fall)  state_d = rw_q ? S_TX : (seg_sel_q ? S_SEG : S_WORD);
                S_WORD:     if (byte_done) state_d = S_WORD_ACK;
                S_WORD_ACK: if (scl_fall)  state_d = S_IGNORE;
                S_SEG:      if (byte_done) state_d = S_SEG_ACK;
                S_SEG_ACK:  if (scl_fall)  state_d = S_IGNORE;
                S_TX:       if (scl_fall && cnt_q == 4'd7) state_d = S_TX_ACK;
                S_TX_ACK:   if (scl_fall)  state_d = acked_q ? S_TX : S_IGNORE;
                S_IGNORE:   state_d = S_IGNORE;
                default:    state_d = S_IDLE;
            endcase
        end
    end

    logic seg_sel_q;

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0; off_q <= '0; seg_q <= '0; txb_q <= '0; cnt_q <= '0;
            rw_q <= 1'b0; seg_sel_q <= 1'b0; acked_q <= 1'b0; oe_q <= 1'b0;
            req_q <= 1'b0; pend_q <= 1'b0;
        end else if (clr) begin
            sh_q <= '0; off_q <= '0; seg_q <= '0; txb_q <= '0; cnt_q <= '0;
            rw_q <= 1'b0; seg_sel_q <= 1'b0; acked_q <= 1'b0; oe_q <= 1'b0;
            req_q <= 1'b0; pend_q <= 1'b0;
        end else begin
            if (req_q && rd_gnt) begin
                req_q  <= 1'b0;
                pend_q <= 1'b1;
            end
            if (pend_q) begin
                txb_q  <= rd_data;
                pend_q <= 1'b0;
            end
            if (start_det) begin
                cnt_q <= '0;
                oe_q  <= 1'b0;
            end else if (stop_det) begin
                cnt_q <= '0;
                oe_q  <= 1'b0;
                seg_q <= '0;
            end else begin
                case (state_q)
                    S_ADDR, S_WORD, S_SEG: begin
                        if (scl_rise) begin
                            sh_q  <= {sh_q[6:0], sda_s};
                            cnt_q <= cnt_q + 4'd1;
                        end else if (byte_done) begin
                            cnt_q <= '0;
                            if (state_q == S_ADDR) begin
                                if (addr_hit) begin
                                    oe_q      <= 1'b1;
                                    rw_q      <= sh_q[0];
                                    seg_sel_q <= hit_seg;
                                    if (sh_q[0]) req_q <= 1'b1;
                                end
                            end else if (state_q == S_WORD) begin
                                off_q <= sh_q;
                                oe_q  <= 1'b1;
                            end else begin
                                seg_q <= (HAS_SEG != 0) ? sh_q : '0;
                                oe_q  <= 1'b1;
                            end
                        end
                    end
                    S_ADDR_ACK: begin
                        if (scl_fall) begin
                            cnt_q <= '0;
                            if (rw_q) begin
                                sh_q  <= txb_q;
                                oe_q  <= ~txb_q[7];
                                off_q <= off_q + 8'd1;
                            end else begin
                                oe_q <= 1'b0;
                            end
                        end
                    end
                    S_WORD_ACK, S_SEG_ACK: begin
                        if (scl_fall) oe_q <= 1'b0;
                    end
                    S_TX: begin
                        if (scl_fall) begin
                            if (cnt_q == 4'd7) begin
                                oe_q  <= 1'b0;
                                cnt_q <= '0;
                            end else begin
                                cnt_q <= cnt_q + 4'd1;
                                sh_q  <= {sh_q[6:0], 1'b0};
                                oe_q  <= ~sh_q[6];
                            end
                        end
                    end
                    S_TX_ACK: begin
                        if (scl_rise) begin
                            acked_q <= ~sda_s;
                            if (!sda_s) req_q <= 1'b1;
                        end else if (scl_fall && acked_q) begin
                            sh_q  <= txb_q;
                            oe_q  <= ~txb_q[7];
                            off_q <= off_q + 8'd1;
                            cnt_q <= '0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe  = oe_q;
    assign rd_req  = req_q;
    assign rd_addr = (split || HAS_SEG == 0) ? (ADDR_W'(BASE) + ADDR_W'(off_q))
                                             : ADDR_W'({seg_q, off_q});

    // R9: no pull-low while the port is idle or ignoring the bus
    p_quiet_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE || state_q == S_IGNORE) |-> !oe_q);

    // R5: a STOP leaves the segment pointer at zero
    p_seg_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (seg_q == '0));

    // R3: the first data byte is fetched before it has to be shifted out
    p_data_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ADDR_ACK && scl_fall && rw_q) |-> !(req_q || pend_q));

    // R10: a RAM request waits at most one cycle for its grant
    p_req_served_r10: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (req_q && !rd_gnt) |=> rd_gnt);
endmodule

// File: rtl/edid_dual_responder.sv
module edid_dual_responder
    import edid_pkg::*;
#(
    parameter int ADDR_W      = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_reset,
    input  logic              split_mode,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              hdmi_scl,
    input  logic              hdmi_sda,
    output logic              hdmi_sda_oe,
    input  logic              vga_scl,
    input  logic              vga_sda,
    output logic              vga_sda_oe
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int HALF  = DEPTH / 2;
    localparam int NPORT = 2;

    logic [NPORT-1:0]  scl_v, sda_v, oe_v, req_v, gnt_v;
    logic [ADDR_W-1:0] addr_v [NPORT];
    edid_byte_t        rdata;

    assign scl_v = {vga_scl, hdmi_scl};
    assign sda_v = {vga_sda, hdmi_sda};
    assign hdmi_sda_oe = oe_v[0];
    assign vga_sda_oe  = oe_v[1];

    // Port 0 carries the segment pointer and sits at the bottom of the RAM;
    // port 1 has none and reads the upper half.
    for (genvar i = 0; i < NPORT; i++) begin : g_port
        edid_ddc_port #(
            .ADDR_W     (ADDR_W),
            .HAS_SEG    ((i == 0) ? 1 : 0),
            .BASE       (i * HALF),
            .SYNC_STAGES(SYNC_STAGES)
        ) u_port (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (sw_reset),
            .split  (split_mode),
            .scl_i  (scl_v[i]),
            .sda_i  (sda_v[i]),
            .sda_oe (oe_v[i]),
            .rd_req (req_v[i]),
            .rd_addr(addr_v[i]),
            .rd_gnt (gnt_v[i]),
            .rd_data(rdata)
        );
    end

    edid_ram_arb #(.ADDR_W(ADDR_W)) u_ram (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .req    (req_v),
        .addr0  (addr_v[0]),
        .addr1  (addr_v[1]),
        .gnt    (gnt_v),
        .rdata  (rdata)
    );

    // R7: in the single-image layout port 1 never pulls its data line low
    p_vga_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !split_mode |-> !vga_sda_oe);
endmodule

// File: tb/tb_edid_dual_responder.sv
`timescale 1ns/1ps
module tb_edid_dual_responder;
    localparam int Q = 6;

    logic       clk = 1'b0;
    logic       rst_n, sw_reset, split_mode, wr_en;
    logic [8:0] wr_addr;
    logic [7:0] wr_data;
    logic [1:0] m_scl, m_sda;
    logic       hdmi_sda_oe, vga_sda_oe, hdmi_line, vga_line;
    logic [7:0] rbuf [2][4];
    int         total = 0, fails = 0;

    always #4 clk = ~clk;

    assign hdmi_line = m_sda[0] & ~hdmi_sda_oe;
    assign vga_line  = m_sda[1] & ~vga_sda_oe;

    edid_dual_responder dut (
        .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .split_mode(split_mode),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .hdmi_scl(m_scl[0]), .hdmi_sda(hdmi_line), .hdmi_sda_oe(hdmi_sda_oe),
        .vga_scl(m_scl[1]), .vga_sda(vga_line), .vga_sda_oe(vga_sda_oe));

    function automatic logic [7:0] pat(int a);
        return a[7:0] ^ ((a[8]) ? 8'hA5 : 8'h3C);
    endfunction

    function automatic logic line(int p);
        return (p != 0) ? vga_line : hdmi_line;
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic q();
        repeat (Q) @(posedge clk);
        #1;
    endtask

    task automatic i2c_start(int p);
        m_sda[p] = 1'b1; q(); m_scl[p] = 1'b1; q();
        m_sda[p] = 1'b0; q(); m_scl[p] = 1'b0; q();
    endtask

    task automatic i2c_stop(int p);
        m_sda[p] = 1'b0; q(); m_scl[p] = 1'b1; q(); m_sda[p] = 1'b1; q();
    endtask

    task automatic wb(int p, logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda[p] = b[i]; q(); m_scl[p] = 1'b1; q(); m_scl[p] = 1'b0; q();
        end
        m_sda[p] = 1'b1; q(); m_scl[p] = 1'b1; q();
        ack = !line(p);
        m_scl[p] = 1'b0; q();
    endtask

    task automatic rb(int p, bit ackit, output logic [7:0] b);
        b = '0;
        for (int i = 0; i < 8; i++) begin
            m_sda[p] = 1'b1; q(); m_scl[p] = 1'b1; q();
            b = {b[6:0], line(p)};
            m_scl[p] = 1'b0; q();
        end
        m_sda[p] = ackit ? 1'b0 : 1'b1; q(); m_scl[p] = 1'b1; q();
        m_scl[p] = 1'b0; q(); m_sda[p] = 1'b1;
    endtask

    task automatic rd_at(int p, bit use_seg, logic [7:0] seg, logic [7:0] off,
                         int n, output bit ok);
        bit a;
        ok = 1'b1;
        i2c_start(p);
        if (use_seg) begin
            wb(p, 8'h60, a); ok &= a;
            wb(p, seg, a);   ok &= a;
            i2c_start(p);
        end
        wb(p, 8'hA0, a); ok &= a;
        wb(p, off, a);   ok &= a;
        i2c_start(p);
        wb(p, 8'hA1, a); ok &= a;
        for (int i = 0; i < n; i++) rb(p, i != n - 1, rbuf[p][i]);
        i2c_stop(p);
    endtask

    task automatic rd_cur(int p, int n, output bit ok);
        bit a;
        i2c_start(p);
        wb(p, 8'hA1, a); ok = a;
        for (int i = 0; i < n; i++) rb(p, i != n - 1, rbuf[p][i]);
        i2c_stop(p);
    endtask

    task automatic set_off(int p, logic [7:0] off, output bit ok);
        bit a;
        i2c_start(p);
        wb(p, 8'hA0, a); ok = a;
        wb(p, off, a);   ok &= a;
        i2c_stop(p);
    endtask

    task automatic probe(int p, logic [7:0] b, output bit ack);
        i2c_start(p);
        wb(p, b, ack);
        i2c_stop(p);
    endtask

    task automatic t_reset();
        bit ok;
        chk("R1 port0 released after reset", hdmi_sda_oe, 0);
        chk("R1 port1 released after reset", vga_sda_oe, 0);
        rd_cur(0, 1, ok);
        chk("R1 current read acked", ok, 1);
        chk("R1 offset starts at 0", rbuf[0][0], pat(0));
    endtask

    task automatic t_offset_read();
        bit ok;
        rd_at(0, 0, 0, 8'h10, 1, ok);
        chk("R3 offset read acked", ok, 1);
        chk("R3 byte at 0x010", rbuf[0][0], pat(16));
        rd_at(0, 0, 0, 8'h9C, 1, ok);
        chk("R3 byte at 0x09C", rbuf[0][0], pat(156));
    endtask

    task automatic t_wrap();
        bit ok;
        rd_at(0, 0, 0, 8'hFE, 3, ok);
        chk("R4 burst byte0", rbuf[0][0], pat(254));
        chk("R4 burst byte1", rbuf[0][1], pat(255));
        chk("R4 wrap to 0x000", rbuf[0][2], pat(0));
        rd_at(0, 1, 8'h01, 8'hFF, 2, ok);
        chk("R4 segment 1 byte 0x1FF", rbuf[0][0], pat(511));
        chk("R4 wrap stays in segment 1", rbuf[0][1], pat(256));
    endtask

    task automatic t_segment();
        bit ok;
        rd_at(0, 1, 8'h01, 8'h05, 2, ok);
        chk("R5 segment write acked", ok, 1);
        chk("R5 segment 1 byte 0x105", rbuf[0][0], pat(261));
        chk("R5 segment 1 byte 0x106", rbuf[0][1], pat(262));
        rd_at(0, 0, 0, 8'h05, 1, ok);
        chk("R5 segment cleared by STOP", rbuf[0][0], pat(5));
    endtask

    task automatic t_current();
        bit ok;
        rd_cur(0, 2, ok);
        chk("R12 current read continues", rbuf[0][0], pat(6));
        chk("R12 current read second byte", rbuf[0][1], pat(7));
    endtask

    task automatic t_vga_single();
        bit a;
        probe(1, 8'hA0, a);
        chk("R7 port1 ignores 0x50 in single layout", a, 0);
        probe(1, 8'h60, a);
        chk("R7 port1 ignores 0x30", a, 0);
        chk("R7 port1 line released", vga_sda_oe, 0);
    endtask

    task automatic t_split();
        bit ok, a;
        split_mode = 1'b1;
        rd_at(0, 1, 8'h01, 8'h20, 1, ok);
        chk("R6 port0 lower half despite segment", rbuf[0][0], pat(32));
        rd_at(1, 0, 0, 8'h20, 2, ok);
        chk("R6 port1 read acked", ok, 1);
        chk("R6 port1 byte 0x120", rbuf[1][0], pat(288));
        chk("R6 port1 byte 0x121", rbuf[1][1], pat(289));
        probe(1, 8'h60, a);
        chk("R7 port1 ignores 0x30 in split layout", a, 0);
    endtask

    task automatic t_bad_addr();
        bit a;
        probe(0, 8'hA2, a);
        chk("R8 address 0x51 not acked", a, 0);
        probe(0, 8'h61, a);
        chk("R8 segment read not acked", a, 0);
        chk("R8 line released", hdmi_sda_oe, 0);
    endtask

    task automatic t_release();
        bit ok;
        rd_at(0, 0, 0, 8'h30, 1, ok);
        chk("R9 released after master NACK", hdmi_sda_oe, 0);
        chk("R9 line high after NACK", hdmi_line, 1);
    endtask

    task automatic t_concurrent();
        bit ok0, ok1;
        set_off(0, 8'h40, ok0);
        set_off(1, 8'h40, ok1);
        fork
            rd_cur(0, 2, ok0);
            rd_cur(1, 2, ok1);
        join
        chk("R10 port0 byte0 under conflict", rbuf[0][0], pat(64));
        chk("R10 port0 byte1 under conflict", rbuf[0][1], pat(65));
        chk("R10 port1 byte0 under conflict", rbuf[1][0], pat(320));
        chk("R10 port1 byte1 under conflict", rbuf[1][1], pat(321));
    endtask

    task automatic t_sw_reset();
        bit ok;
        set_off(0, 8'h33, ok);
        set_off(1, 8'h77, ok);
        @(posedge clk); #1 sw_reset = 1'b1;
        @(posedge clk); #1 sw_reset = 1'b0;
        rd_cur(0, 1, ok);
        chk("R11 port0 offset cleared", rbuf[0][0], pat(0));
        rd_cur(1, 1, ok);
        chk("R11 port1 offset cleared, RAM kept", rbuf[1][0], pat(256));
    endtask

    task automatic t_host_write();
        bit ok;
        @(posedge clk); #1 wr_en = 1'b1; wr_addr = 9'h1FF; wr_data = 8'h5A;
        @(posedge clk); #1 wr_en = 1'b0;
        rd_at(1, 0, 0, 8'hFF, 1, ok);
        chk("R2 host write visible", rbuf[1][0], 8'h5A);
    endtask

    initial begin
        rst_n = 1'b0; sw_reset = 1'b0; split_mode = 1'b0; wr_en = 1'b0;
        wr_addr = '0; wr_data = '0; m_scl = 2'b11; m_sda = 2'b11;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        for (int a = 0; a < 512; a++) begin
            @(posedge clk); #1;
            wr_en = 1'b1; wr_addr = 9'(a); wr_data = pat(a);
        end
        @(posedge clk); #1 wr_en = 1'b0;
        q();
        t_reset();
        t_offset_read();
        t_wrap();
        t_segment();
        t_current();
        t_vga_single();
        t_bad_addr();
        t_release();
        t_split();
        t_concurrent();
        t_sw_reset();
        t_host_write();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule